// File: doc/BRIEF.md
# Word-Parallel CRC-32 Frame Check Generator

This block computes the 32-bit Ethernet-style frame check value over a stream of data words. Each clock cycle it can absorb a whole word. The next register value is found by a combinational chain of single-bit Galois shift stages, one stage per data bit. The generator polynomial is 0x04C11DB7, written without its implicit x^32 term, and the register starts from all ones. Bit 0 of each word enters the register first. The finished value is the bit-reversed, inverted form of the register.

A frame begins with the `sof` strobe. When `sof` is high, the preset value is used as the seed in place of the current register. If `valid` is also high in that cycle, the first word of the new frame is absorbed at once. If `valid` is low, the register is only reloaded. Words taken with `valid` alone continue the running check. The byte that comes first in the frame sits in bits 7:0 of the word. `crc_out` always shows the finished value of everything absorbed so far.

A small control machine records the frame phase. It has two states:
- `PH_FRESH`: the register holds the preset and no word has been absorbed since reset or since an `sof` without `valid`.
- `PH_ACCUM`: at least one word has been absorbed.

Its transitions are:
- FRESH to ACCUM on any `valid`.
- ACCUM to FRESH on `sof` without `valid`.
- Reset goes to FRESH.
- In every other case the state holds.

Top module: `crc32_par_gen`

## Requirements
- R1: A cycle with `rst` high leaves `crc_state` at 0xFFFFFFFF and `crc_out` at 0x00000000.
- R2: A cycle with `valid` and `sof` both low leaves `crc_state` unchanged, whatever is on `data`.
- R3: A cycle with `valid` high advances the register by DATA_W Galois shifts with polynomial 0x04C11DB7 (feedback = register bit 31 XOR data bit; shift left; XOR the polynomial when the feedback is 1). The data bits are taken in the order bit 0 first.
- R4: A cycle with `sof` and `valid` both high absorbs `data` starting from the preset 0xFFFFFFFF. Whatever was accumulated before is discarded.
- R5: A cycle with `sof` high and `valid` low reloads `crc_state` to 0xFFFFFFFF. A later `valid` word then continues from the preset.
- R6: `crc_out` equals the bitwise inverse of `crc_state` with bit order reversed (`crc_out[i] = ~crc_state[31-i]`). It is updated in the same cycle as the register.
- R7: After the last word of a frame, `crc_out` equals the standard CRC-32 of the frame bytes, with the first byte in bits 7:0. At DATA_W = 8 the ASCII bytes "123456789" give 0xCBF43926.
- R8: `rst` takes priority over `sof` and `valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sof | input | 1 | Start-of-frame strobe; the preset is used as the seed |
| valid | input | 1 | Absorb `data` this cycle |
| data | input | DATA_W | Data word; bit 0 is taken first, and the first byte of the frame is in bits 7:0 |
| crc_state | output | 32 | Running CRC register (non-reflected) |
| crc_out | output | 32 | Finished check value: reflected and inverted |

## Verification
The assertions check these properties on every cycle:
- The register holds on idle cycles.
- An `sof` without `valid` reloads the preset.
- The first cycle after reset shows the preset.
- The control phase agrees with the register: in FRESH the register is at the preset, and any `valid` moves the phase to ACCUM.

Only the bench scenarios can show that the absorbed value is correct, because that needs a reference. The bench compares multi-word random frames against an independent reflected bit-serial model. It also checks the "123456789" result on an 8-bit instance, the seed taken on `sof` together with `valid`, and reset priority.

// File: rtl/crc32_pkg.sv
package crc32_pkg;

    localparam int CRC_W = 32;
    localparam logic [CRC_W-1:0] CRC_POLY   = 32'h04C11DB7;
    localparam logic [CRC_W-1:0] CRC_PRESET = 32'hFFFFFFFF;

    // Frame phase of the generator
    typedef enum logic [0:0] {
        PH_FRESH = 1'b0,
        PH_ACCUM = 1'b1
    } crc_phase_e;

endpackage

// File: rtl/crc32_bit_step.sv
// One Galois shift of the non-reflected CRC register.
module crc32_bit_step
    import crc32_pkg::*;
#(
    parameter int W = CRC_W,
    parameter logic [W-1:0] POLY = CRC_POLY
) (
    input  logic [W-1:0] s_in,
    input  logic         d_in,
    output logic [W-1:0] s_out
);
    logic fb;

    always_comb begin
        fb    = s_in[W-1] ^ d_in;
        s_out = {s_in[W-2:0], 1'b0} ^ ({W{fb}} & POLY);
    end
endmodule

// File: rtl/crc32_word_step.sv
// Unrolled next-state function: DATA_W shifts in a row, bit 0 first.
module crc32_word_step
    import crc32_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int W = CRC_W,
    parameter logic [W-1:0] POLY = CRC_POLY
) (
    input  logic [W-1:0]      seed,
    input  logic [DATA_W-1:0] word,
    output logic [W-1:0]      next
);
    localparam int STAGES = DATA_W;

    logic [W-1:0] chain [STAGES+1];

    assign chain[0] = seed;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        crc32_bit_step #(
            .W    (W),
            .POLY (POLY)
        ) u_step (
            .s_in  (chain[g]),
            .d_in  (word[g]),
            .s_out (chain[g+1])
        );
    end

    assign next = chain[STAGES];
endmodule

// File: rtl/crc32_out_map.sv
// Finished value: bit-reverse the register and invert it.
module crc32_out_map #(
    parameter int W = 32
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] fcs
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign fcs[i] = ~raw[W-1-i];
    end
endmodule

// File: rtl/crc32_par_gen.sv
module crc32_par_gen
    import crc32_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sof,
    input  logic              valid,
    input  logic [DATA_W-1:0] data,
    output logic [CRC_W-1:0]  crc_state,
    output logic [CRC_W-1:0]  crc_out
);
    crc_phase_e       ph_q, ph_d;
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] seed;
    logic [CRC_W-1:0] crc_nxt;
    logic [CRC_W-1:0] crc_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_FRESH;
            crc_q <= CRC_PRESET;
        end else begin
            ph_q  <= ph_d;
            crc_q <= crc_d;
        end
    end

    // Phase transitions
    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_FRESH: if (valid)        ph_d = PH_ACCUM;
            PH_ACCUM: if (sof && !valid) ph_d = PH_FRESH;
        endcase
    end

    // Datapath: seed select and register load
    always_comb begin
        seed  = sof ? CRC_PRESET : crc_q;
        crc_d = crc_q;
        if (valid)    crc_d = crc_nxt;
        else if (sof) crc_d = CRC_PRESET;
    end

    crc32_word_step #(
        .DATA_W (DATA_W),
        .W      (CRC_W),
        .POLY   (CRC_POLY)
    ) u_word (
        .seed (seed),
        .word (data),
        .next (crc_nxt)
    );

    crc32_out_map #(
        .W (CRC_W)
    ) u_map (
        .raw (crc_q),
        .fcs (crc_out)
    );

    assign crc_state = crc_q;
endmodule

// File: rtl/crc32_par_gen_chk.sv
module crc32_par_gen_chk
    import crc32_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             sof,
    input logic             valid,
    input logic [CRC_W-1:0] crc_state,
    input crc_phase_e       phase
);
    AST_RESET_PRESET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> crc_state == CRC_PRESET); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!valid && !sof) |=> $stable(crc_state)); // R2

    AST_SOF_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (sof && !valid) |=> crc_state == CRC_PRESET); // R5

    AST_FRESH_PRESET: assert property (@(posedge clk) disable iff (rst)
        phase == PH_FRESH |-> crc_state == CRC_PRESET); // R5

    AST_VALID_ACCUM: assert property (@(posedge clk) disable iff (rst)
        valid |=> phase == PH_ACCUM); // R3
endmodule

bind crc32_par_gen crc32_par_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sof       (sof),
    .valid     (valid),
    .crc_state (crc_state),
    .phase     (ph_q)
);

// File: tb/tb_crc32_par_gen.sv
`timescale 1ns/1ps
module tb_crc32_par_gen;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sof = 1'b0, valid = 1'b0;
    logic [DW-1:0] data = '0;
    logic [31:0]   crc_state, crc_out;
    logic          sof8 = 1'b0, valid8 = 1'b0;
    logic [7:0]    data8 = '0;
    logic [31:0]   crc_state8, crc_out8;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    crc32_par_gen #(.DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .sof(sof), .valid(valid), .data(data),
        .crc_state(crc_state), .crc_out(crc_out));

    crc32_par_gen #(.DATA_W(8)) dut8 (
        .clk(clk), .rst(rst), .sof(sof8), .valid(valid8), .data(data8),
        .crc_state(crc_state8), .crc_out(crc_out8));

    // Reference: reflected bit-serial CRC-32, LSB first
    function automatic logic [31:0] ref_absorb(logic [31:0] r, logic [DW-1:0] d, int nbits);
        for (int i = 0; i < nbits; i++) begin
            logic c;
            c = r[0] ^ d[i];
            r = (r >> 1) ^ (c ? 32'hEDB88320 : 32'h0);
        end
        return r;
    endfunction

    function automatic logic [31:0] rev32(logic [31:0] v);
        logic [31:0] o;
        for (int i = 0; i < 32; i++) o[i] = v[31-i];
        return o;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Expected register from reflected reference r
    task automatic chk_ref(string req, logic [31:0] r);
        chk({req, " state"}, crc_state, rev32(r));
        chk({req, " out"}, crc_out, ~r);
    endtask

    task automatic cyc(logic s, logic v, logic [DW-1:0] d);
        sof = s; valid = v; data = d;
        @(negedge clk);
        sof = 1'b0; valid = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset", crc_state, 32'hFFFFFFFF);
        chk("R1 R6 reset out", crc_out, 32'h0);
    endtask

    task automatic t_single;
        logic [DW-1:0] pats [3];
        pats[0] = '0;
        pats[1] = '1;
        pats[2] = 64'h0123_4567_89AB_CDEF;
        for (int k = 0; k < 3; k++) begin
            cyc(1'b1, 1'b1, pats[k]);
            chk_ref("R3 R6 single", ref_absorb(32'hFFFFFFFF, pats[k], DW));
        end
    endtask

    task automatic t_hold;
        logic [31:0] r;
        r = ref_absorb(32'hFFFFFFFF, 64'hDEAD_BEEF_0000_1111, DW);
        cyc(1'b1, 1'b1, 64'hDEAD_BEEF_0000_1111);
        for (int k = 0; k < 3; k++) cyc(1'b0, 1'b0, {$urandom, $urandom});
        chk_ref("R2 hold", r);
    endtask

    task automatic t_frames;
        for (int f = 0; f < 20; f++) begin
            logic [31:0] r;
            int nw;
            r = 32'hFFFFFFFF;
            nw = 1 + (f % 6);
            for (int w = 0; w < nw; w++) begin
                logic [DW-1:0] d;
                d = {$urandom, $urandom};
                r = ref_absorb(r, d, DW);
                cyc(w == 0, 1'b1, d);
                if (w == 1) cyc(1'b0, 1'b0, '1);
            end
            chk_ref("R7 R3 frame", r);
        end
    endtask

    task automatic t_sof_valid;
        logic [DW-1:0] d;
        cyc(1'b1, 1'b1, 64'h5555_AAAA_5555_AAAA);
        cyc(1'b0, 1'b1, 64'h1234_1234_1234_1234);
        d = 64'hFEDC_BA98_7654_3210;
        cyc(1'b1, 1'b1, d);
        chk_ref("R4 sof+valid seed", ref_absorb(32'hFFFFFFFF, d, DW));
    endtask

    task automatic t_sof_only;
        logic [DW-1:0] d;
        cyc(1'b0, 1'b1, 64'h7777_0000_7777_0000);
        cyc(1'b1, 1'b0, '1);
        chk("R5 sof reload", crc_state, 32'hFFFFFFFF);
        d = 64'h0F0F_0F0F_F0F0_F0F0;
        cyc(1'b0, 1'b1, d);
        chk_ref("R5 continue from preset", ref_absorb(32'hFFFFFFFF, d, DW));
    endtask

    task automatic t_string;
        string s;
        logic [31:0] r;
        s = "123456789";
        r = 32'hFFFFFFFF;
        for (int i = 0; i < s.len(); i++) begin
            sof8 = (i == 0); valid8 = 1'b1; data8 = s[i];
            r = ref_absorb(r, {56'h0, s[i]}, 8);
            @(negedge clk);
        end
        sof8 = 1'b0; valid8 = 1'b0;
        chk("R7 check string", crc_out8, 32'hCBF43926);
        chk("R7 check string ref", crc_out8, ~r);
        // 64-bit instance, "12345678" as one word
        cyc(1'b1, 1'b1, 64'h3837_3635_3433_3231);
        chk_ref("R7 eight bytes", ref_absorb(32'hFFFFFFFF, 64'h3837_3635_3433_3231, DW));
    endtask

    task automatic t_rst_prio;
        cyc(1'b0, 1'b1, 64'h1111_2222_3333_4444);
        rst = 1'b1;
        cyc(1'b1, 1'b1, 64'h9999_8888_7777_6666);
        rst = 1'b0;
        chk("R8 reset priority", crc_state, 32'hFFFFFFFF);
        chk("R8 reset priority out", crc_out, 32'h0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_single();
        t_hold();
        t_frames();
        t_sof_valid();
        t_sof_only();
        t_string();
        t_rst_prio();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule